// File: doc/BRIEF.md
# Panel Power-Up Sequencer

This block powers up a flat panel and its backlight one step at a time, in a fixed order. The steps are: an initial step that holds every control line low, panel supply, serial link release, backlight supply, backlight PWM enable, and backlight enable. A done flag follows the last step. The first four steps are each followed by a wait, programmed in milliseconds and counted on an external 1 ms tick. The later steps follow one another without a wait.

The sequence can be advanced in two ways. A `start_run` pulse makes the block step on its own as each wait expires, until it reaches done. A `poll_req` pulse asks for one step only. If the current wait has not yet expired, the request is refused at once and reported on `step_defer`, and the block's state is left untouched. This suits firmware that polls the block from a busy main loop.

When the PWM step runs, the block also presents a fixed request to the PWM generator on its outputs: 32768 Hz, duty code 0xDF, divider 1. The PWM waveform itself is produced elsewhere.

Top module: `panel_pwr_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state is the initial step: all five control outputs low, `seq_done`, `step_ack` and `step_defer` low, and the PWM request fields zero.
- R2: The control outputs rise in the order `panel_vdd_en`, `link_enable`, `bl_vdd_en`, `pwm_enable`, `bl_enable`. At most one rises per clock, and none falls until reset.
- R3: The initial step runs as soon as it is requested, with no wait. It leaves all control outputs low.
- R4: Step k (0 = initial, 1 = panel, 2 = link, 3 = backlight supply) is followed by a wait given by `cfg_delay[16k+15:16k]`. This wait equals the number of `ms_tick` pulses sampled strictly between the clock edge that runs step k and the edge that runs step k+1. A tick sampled at the edge that runs a step is not counted.
- R5: The PWM step is followed by no wait. During a run, `bl_enable` rises one clock after `pwm_enable`, and `seq_done` rises together with `bl_enable`.
- R6: A programmed wait of 0 lets the next step run at the next clock.
- R7: A `poll_req` made while a wait is still running changes no control output. It gives a one-clock `step_defer` pulse in the next cycle and no `step_ack`.
- R8: A `poll_req` made once the wait has expired runs exactly one step. It gives a one-clock `step_ack` pulse in the next cycle, in which that step's output is already visible.
- R9: After a `start_run` pulse, the block runs every remaining step with no further request and stops at done.
- R10: Once `seq_done` is high, `start_run` and `poll_req` have no effect. The outputs hold, and neither `step_ack` nor `step_defer` pulses.
- R11: While `pwm_enable` is high, `pwm_freq_hz` = 32768, `pwm_duty` = 0xDF and `pwm_div` = 1. While it is low, all three are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_run | input | 1 | Pulse: run the remaining steps to done |
| poll_req | input | 1 | Pulse: run one step if its wait has expired |
| ms_tick | input | 1 | One-clock pulse every millisecond |
| cfg_delay | input | 64 | Four 16-bit waits in ms; wait k in bits [16k+15:16k] |
| panel_vdd_en | output | 1 | Panel supply enable |
| link_enable | output | 1 | Serial link shutdown release |
| bl_vdd_en | output | 1 | Backlight supply enable |
| pwm_enable | output | 1 | Backlight PWM enable |
| bl_enable | output | 1 | Backlight enable |
| seq_done | output | 1 | All steps complete |
| step_ack | output | 1 | Pulse: a step was run |
| step_defer | output | 1 | Pulse: a poll was refused because a wait is running |
| pwm_freq_hz | output | 16 | Requested PWM frequency in Hz |
| pwm_duty | output | 8 | Requested PWM duty code |
| pwm_div | output | 4 | Requested PWM divider |

## Verification
A wrong step index shows at the ports within one clock. An output rises out of order, or two rise together, or `seq_done` appears without `bl_enable`. A wrong or mis-loaded wait counter does not show until the next step. That step then starts a fixed number of ticks early or late, so the bench counts the ticks between consecutive rising edges and compares the count with the programmed value. Errors in the request path appear in the cycle after a request, as a missing or extra `step_ack` or `step_defer`, or as an output that moves when it should not.

// File: rtl/pps_pkg.sv
// Package: shared step encoding for the panel power sequencer.
// Assumes the step order is fixed; the encoding is ordered so that the
// rail driven by a step can be found as (step index - 1).
package pps_pkg;

    typedef enum logic [2:0] {
        ST_INIT  = 3'd0,
        ST_PANEL = 3'd1,
        ST_LINK  = 3'd2,
        ST_BLSUP = 3'd3,
        ST_PWM   = 3'd4,
        ST_BLEN  = 3'd5,
        ST_DONE  = 3'd6
    } step_e;

    localparam int NUM_RAILS = 5;

    // Successor of a step; done is terminal.
    function automatic step_e next_step(step_e s);
        case (s)
            ST_INIT:  return ST_PANEL;
            ST_PANEL: return ST_LINK;
            ST_LINK:  return ST_BLSUP;
            ST_BLSUP: return ST_PWM;
            ST_PWM:   return ST_BLEN;
            default:  return ST_DONE;
        endcase
    endfunction

endpackage

// File: rtl/pps_delay_timer.sv
// Module: millisecond down-counter for the wait between steps.
// Loads a new wait when a step runs; a load takes priority over a tick
// in the same cycle. Counts down on ms_tick and stops at zero.
module pps_delay_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: hold the remaining wait in ms.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (tick && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pps_step_ctrl.sv
// Module: step controller. Tracks the next step to run and decides when
// it runs. A blocking run (start_run) or a single poll can run a step.
// The initial step never waits; later steps wait for the timer.
// It also selects the wait that follows the step being run.
// Assumes NUM_DLY does not exceed the number of steps before done.
module pps_step_ctrl
    import pps_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_DLY = 4,
    localparam int CFG_W  = NUM_DLY * CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_run,
    input  logic             poll_req,
    input  logic [CFG_W-1:0] cfg_delay,
    input  logic             timer_expired,
    output step_e            cur_step,
    output logic             step_fire,
    output logic [CNT_W-1:0] step_wait,
    output logic             ack_q,
    output logic             defer_q,
    output logic             at_done
);

    step_e step_q;
    logic  run_q;
    logic  ready;
    logic  want;

    assign ready     = (step_q == ST_INIT) || timer_expired;
    assign at_done   = (step_q == ST_DONE);
    assign want      = start_run || run_q || poll_req;
    assign step_fire = want && ready && !at_done;
    assign cur_step  = step_q;

    // Purpose: pick the wait that follows the current step (none past the table).
    always_comb begin
        step_wait = '0;
        for (int i = 0; i < NUM_DLY; i++) begin
            if (int'(step_q) == i)
                step_wait = cfg_delay[i*CNT_W +: CNT_W];
        end
    end

    // Purpose: advance the step index when a step runs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            step_q <= ST_INIT;
        else if (step_fire)
            step_q <= next_step(step_q);
    end

    // Purpose: hold blocking-run mode until the last step runs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= 1'b0;
        else if (at_done || (step_fire && step_q == ST_BLEN))
            run_q <= 1'b0;
        else if (start_run)
            run_q <= 1'b1;
    end

    // Purpose: report each request's outcome one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            defer_q <= 1'b0;
        end else begin
            ack_q   <= step_fire;
            defer_q <= poll_req && !start_run && !run_q && !ready && !at_done;
        end
    end

endmodule

// File: rtl/pps_rail_drv.sv
// Module: registered control outputs, one per powered step.
// Rail g rises when step g+1 runs. The initial step clears every rail.
module pps_rail_drv
    import pps_pkg::*;
#(
    parameter int N_RAIL = NUM_RAILS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_fire,
    input  step_e             cur_step,
    output logic [N_RAIL-1:0] rails
);

    for (genvar g = 0; g < N_RAIL; g++) begin : g_rail
        // Purpose: set or clear one control output.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rails[g] <= 1'b0;
            else if (step_fire && cur_step == ST_INIT)
                rails[g] <= 1'b0;
            else if (step_fire && int'(cur_step) == g + 1)
                rails[g] <= 1'b1;
        end
    end

endmodule

// File: rtl/panel_pwr_seq.sv
// Module: panel power-up sequencer top. Joins the step controller, the
// wait timer and the rail drivers, and presents the fixed PWM request
// while the PWM rail is on. Assumes ms_tick is a single-clock pulse.
module panel_pwr_seq
    import pps_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int NUM_DLY     = 4,
    parameter int FREQ_W      = 16,
    parameter int DUTY_W      = 8,
    parameter int DIV_W       = 4,
    parameter int PWM_FREQ_HZ = 32768,
    parameter int PWM_DUTY    = 8'hDF,
    parameter int PWM_DIV     = 1,
    localparam int CFG_W      = NUM_DLY * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_run,
    input  logic              poll_req,
    input  logic              ms_tick,
    input  logic [CFG_W-1:0]  cfg_delay,
    output logic              panel_vdd_en,
    output logic              link_enable,
    output logic              bl_vdd_en,
    output logic              pwm_enable,
    output logic              bl_enable,
    output logic              seq_done,
    output logic              step_ack,
    output logic              step_defer,
    output logic [FREQ_W-1:0] pwm_freq_hz,
    output logic [DUTY_W-1:0] pwm_duty,
    output logic [DIV_W-1:0]  pwm_div
);

    step_e                cur_step;
    logic                 step_fire;
    logic [CNT_W-1:0]     step_wait;
    logic                 timer_expired;
    logic [NUM_RAILS-1:0] rails;

    pps_step_ctrl #(.CNT_W(CNT_W), .NUM_DLY(NUM_DLY)) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_run     (start_run),
        .poll_req      (poll_req),
        .cfg_delay     (cfg_delay),
        .timer_expired (timer_expired),
        .cur_step      (cur_step),
        .step_fire     (step_fire),
        .step_wait     (step_wait),
        .ack_q         (step_ack),
        .defer_q       (step_defer),
        .at_done       (seq_done)
    );

    pps_delay_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (step_fire),
        .load_val (step_wait),
        .tick     (ms_tick),
        .expired  (timer_expired)
    );

    pps_rail_drv #(.N_RAIL(NUM_RAILS)) rails_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_fire (step_fire),
        .cur_step  (cur_step),
        .rails     (rails)
    );

    assign panel_vdd_en = rails[0];
    assign link_enable  = rails[1];
    assign bl_vdd_en    = rails[2];
    assign pwm_enable   = rails[3];
    assign bl_enable    = rails[4];

    // Purpose: PWM request fields, valid only while the PWM rail is on.
    assign pwm_freq_hz = pwm_enable ? FREQ_W'(PWM_FREQ_HZ) : '0;
    assign pwm_duty    = pwm_enable ? DUTY_W'(PWM_DUTY)    : '0;
    assign pwm_div     = pwm_enable ? DIV_W'(PWM_DIV)      : '0;

endmodule

// File: rtl/pps_checker.sv
// Module: property checker for panel_pwr_seq, attached by bind.
// Watches only top-level ports.
module pps_checker (
    input logic clk,
    input logic rst_n,
    input logic panel_vdd_en,
    input logic link_enable,
    input logic bl_vdd_en,
    input logic pwm_enable,
    input logic bl_enable,
    input logic seq_done,
    input logic step_ack,
    input logic step_defer
);

    logic [4:0] rails;
    assign rails = {bl_enable, pwm_enable, bl_vdd_en, link_enable, panel_vdd_en};

    // R2: a later rail is never on without the one before it
    p_rail_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_enable || panel_vdd_en) && (!bl_vdd_en || link_enable) &&
        (!pwm_enable || bl_vdd_en) && (!bl_enable || pwm_enable));

    // R2: at most one rail rises per clock
    p_one_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rails & ~$past(rails)) <= 1);

    // R5: done never appears without the backlight enable
    p_done_bl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> bl_enable);

    // R7: a refused poll leaves every rail unchanged
    p_defer_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step_defer |-> (rails == $past(rails)) && !step_ack);

    // R10: done is sticky and silences the request interface
    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> seq_done && $stable(rails) && !step_ack && !step_defer);

endmodule

bind panel_pwr_seq pps_checker chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .panel_vdd_en (panel_vdd_en),
    .link_enable  (link_enable),
    .bl_vdd_en    (bl_vdd_en),
    .pwm_enable   (pwm_enable),
    .bl_enable    (bl_enable),
    .seq_done     (seq_done),
    .step_ack     (step_ack),
    .step_defer   (step_defer)
);

// File: tb/panel_pwr_seq_tb.sv
// Bench: sweeps every combination of waits 0..3 in blocking mode, then
// exercises polling, the done state and reset in the middle of a run.
module panel_pwr_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_run = 1'b0;
    logic        poll_req = 1'b0;
    logic        ms_tick = 1'b0;
    logic [63:0] cfg_delay = '0;
    logic        panel_vdd_en, link_enable, bl_vdd_en, pwm_enable, bl_enable;
    logic        seq_done, step_ack, step_defer;
    logic [15:0] pwm_freq_hz;
    logic [7:0]  pwm_duty;
    logic [3:0]  pwm_div;
    logic [4:0]  rails;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    assign rails = {bl_enable, pwm_enable, bl_vdd_en, link_enable, panel_vdd_en};

    always #10 clk = ~clk;

    panel_pwr_seq dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_run    (start_run),
        .poll_req     (poll_req),
        .ms_tick      (ms_tick),
        .cfg_delay    (cfg_delay),
        .panel_vdd_en (panel_vdd_en),
        .link_enable  (link_enable),
        .bl_vdd_en    (bl_vdd_en),
        .pwm_enable   (pwm_enable),
        .bl_enable    (bl_enable),
        .seq_done     (seq_done),
        .step_ack     (step_ack),
        .step_defer   (step_defer),
        .pwm_freq_hz  (pwm_freq_hz),
        .pwm_duty     (pwm_duty),
        .pwm_div      (pwm_div)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start_run = 1'b0; poll_req = 1'b0; ms_tick = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic poll_once(output bit ack, output bit dfr);
        poll_req = 1'b1;
        @(negedge clk);
        poll_req = 1'b0;
        ack = step_ack;
        dfr = step_defer;
    endtask

    task automatic tick_once();
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
    endtask

    // Blocking run with ticks every third cycle; counts ticks between rises.
    task automatic run_combo(input int d0, input int d1, input int d2, input int d3);
        int dd[4];
        int count, nexti, phase, expw;
        bit tickd;
        logic [4:0] prev, fresh;
        string tag;
        dd[0] = d0; dd[1] = d1; dd[2] = d2; dd[3] = d3;
        cfg_delay = {16'(d3), 16'(d2), 16'(d1), 16'(d0)};
        do_reset();
        start_run = 1'b1;
        @(negedge clk);
        start_run = 1'b0;
        check(rails == 5'b0, "R3 initial step keeps rails low", int'(rails), 0);
        count = 0; nexti = 0; phase = 0; prev = '0;
        for (int cyc = 0; cyc < 200 && nexti < 5; cyc++) begin
            ms_tick = (phase == 0);
            tickd = ms_tick;
            phase = (phase + 1) % 3;
            @(negedge clk);
            if ((prev & ~rails) != 0)
                check(1'b0, "R2 rail dropped", int'(rails), int'(prev));
            fresh = rails & ~prev;
            if (fresh != 0) begin
                check(fresh == 5'(1 << nexti), "R2 rail order", int'(fresh), 1 << nexti);
                expw = (nexti < 4) ? dd[nexti] : 0;
                if (nexti == 4)       tag = "R5 no wait after PWM step";
                else if (expw == 0)   tag = "R6 zero wait";
                else if (nexti == 0)  tag = "R3/R4 wait after initial step";
                else                  tag = "R4 programmed wait";
                check(count == expw, tag, count, expw);
                if (nexti == 4)
                    check(seq_done == 1'b1, "R5 done with backlight", int'(seq_done), 1);
                else
                    check(seq_done == 1'b0, "R9 done early", int'(seq_done), 0);
                count = 0;
                nexti++;
                prev = rails;
            end else begin
                count += int'(tickd);
            end
        end
        ms_tick = 1'b0;
        check(nexti == 5, "R9 run reaches done", nexti, 5);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        bit ack, dfr;
        do_reset();
        // R1 reset state
        check(rails == 5'b0, "R1 rails after reset", int'(rails), 0);
        check(!seq_done && !step_ack && !step_defer, "R1 flags after reset",
              int'({seq_done, step_ack, step_defer}), 0);
        check(pwm_freq_hz == 0 && pwm_duty == 0 && pwm_div == 0, "R11 fields idle",
              int'(pwm_duty), 0);

        // R4 R5 R6 R9 exhaustive sweep of waits 0..3
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int c = 0; c < 4; c++)
                    for (int e = 0; e < 4; e++)
                        run_combo(a, b, c, e);

        // R10 done ignores requests
        poll_once(ack, dfr);
        check(!ack && !dfr, "R10 poll at done", int'({ack, dfr}), 0);
        start_run = 1'b1;
        @(negedge clk);
        start_run = 1'b0;
        repeat (2) @(negedge clk);
        check(rails == 5'h1F && seq_done && !step_ack, "R10 start at done",
              int'(rails), 31);

        // R7 R8 polling: waits 2,3,0,1
        cfg_delay = {16'd1, 16'd0, 16'd3, 16'd2};
        do_reset();
        poll_once(ack, dfr);
        check(ack && !dfr && rails == 0, "R8 initial step on poll without wait",
              int'({ack, dfr}), 2);
        poll_once(ack, dfr);
        check(!ack && dfr && rails == 0, "R7 poll before deadline", int'({ack, dfr}), 1);
        tick_once();
        poll_once(ack, dfr);
        check(!ack && dfr && rails == 0, "R7 poll one tick short", int'({ack, dfr}), 1);
        tick_once();
        poll_once(ack, dfr);
        check(ack && rails == 5'b00001, "R8 panel step on poll", int'(rails), 1);
        repeat (3) @(negedge clk);
        check(rails == 5'b00001 && !step_ack, "R8 no step without request", int'(rails), 1);
        poll_once(ack, dfr);
        check(dfr && rails == 5'b00001, "R7 defer during wait of 3", int'(rails), 1);
        repeat (3) tick_once();
        poll_once(ack, dfr);
        check(ack && rails == 5'b00011, "R8 link step on poll", int'(rails), 3);
        poll_once(ack, dfr);
        check(ack && rails == 5'b00111, "R6 zero wait poll", int'(rails), 7);
        check(pwm_freq_hz == 0 && pwm_duty == 0 && pwm_div == 0, "R11 fields before PWM",
              int'(pwm_duty), 0);
        poll_once(ack, dfr);
        check(dfr && rails == 5'b00111, "R7 defer before PWM", int'(rails), 7);
        tick_once();
        poll_once(ack, dfr);
        check(ack && rails == 5'b01111, "R8 PWM step on poll", int'(rails), 15);
        check(pwm_freq_hz == 16'd32768, "R11 PWM frequency", int'(pwm_freq_hz), 32768);
        check(pwm_duty == 8'hDF, "R11 PWM duty", int'(pwm_duty), 223);
        check(pwm_div == 4'd1, "R11 PWM divider", int'(pwm_div), 1);
        poll_once(ack, dfr);
        check(ack && rails == 5'h1F && seq_done, "R5 backlight step without wait",
              int'(rails), 31);
        poll_once(ack, dfr);
        check(!ack && !dfr && rails == 5'h1F, "R10 poll after done", int'({ack, dfr}), 0);

        // R1 reset in the middle of a run
        cfg_delay = '0;
        do_reset();
        start_run = 1'b1;
        @(negedge clk);
        start_run = 1'b0;
        repeat (2) @(negedge clk);
        check(rails == 5'b00011, "R9 zero-wait run progress", int'(rails), 3);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(rails == 0 && !seq_done, "R1 mid-run reset", int'(rails), 0);
        repeat (3) @(negedge clk);
        check(rails == 0 && !step_ack, "R1 run mode cleared by reset", int'(rails), 0);

        summary();
    end

endmodule